// File: doc/BRIEF.md
# Signed/Unsigned 16x16 Multiply Unit with Overflow Flags

This unit multiplies two 16-bit operands for an accumulator-style integer datapath. A mode input selects unsigned or two's complement arithmetic. A second input selects the result form. In the widening form both halves of the 32-bit product come back: the low half goes back to the accumulator and the high half to the extension register. In the truncating form only the low half is returned, for a register destination. That form is always signed, and its second operand may be a register value or an immediate.

Each operation is presented for one cycle with `in_valid`. The outputs are registered and appear one clock later together with `out_valid`, and they hold until the next accepted operation. One overflow condition drives both the carry and the overflow outputs. It is set when the high half of the full product carries information that the low half alone cannot express. For unsigned operands that means the high half is non-zero. For signed operands it means the high half is not a copy of bit 15 of the low half.

Top module: `mul16_flag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `prod_lo`, `prod_hi`, `carry_out` and `ovf_out` are all 0 after that edge.
- R2: `out_valid` is 1 in the cycle after a cycle in which `in_valid` was sampled 1, and 0 otherwise.
- R3: With `signed_mode`=0 and `narrow_form`=0, `{prod_hi, prod_lo}` is the 32-bit product of both operands zero-extended.
- R4: With `signed_mode`=1 and `narrow_form`=0, `{prod_hi, prod_lo}` is the 32-bit two's complement product of both operands sign-extended.
- R5: In unsigned mode, `carry_out` is 1 exactly when the high 16 bits of the product are non-zero.
- R6: In signed arithmetic, `carry_out` is 0 exactly when all 16 high product bits equal bit 15 of the low half, and is 1 otherwise.
- R7: With `narrow_form`=1 the multiply is signed whatever `signed_mode` is. `prod_lo` is the low 16 bits of the signed product, `prod_hi` is 0, and the flags follow R6 on the full signed product.
- R8: `ovf_out` always equals `carry_out`.
- R9: When `in_valid` is 0, `prod_lo`, `prod_hi`, `carry_out` and `ovf_out` keep their previous values in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request, sampled each rising edge |
| op_a | input | 16 | First operand (accumulator or register) |
| op_b | input | 16 | Second operand (register, memory or immediate) |
| signed_mode | input | 1 | 1 = two's complement, 0 = unsigned |
| narrow_form | input | 1 | 1 = truncating signed form, 0 = widening form |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| prod_lo | output | 16 | Low half of the product |
| prod_hi | output | 16 | High half of the product (0 in the truncating form) |
| carry_out | output | 1 | Product does not fit its low half |
| ovf_out | output | 1 | Same value as carry_out |

## Verification
The bench goes after the products at the edges of the number range. 0xFFFF squared unsigned gives 0xFFFE0001. 0x8000 squared signed gives 0x40000000. 0x8000 times -1 gives +32768, whose low half has bit 15 set under an all-zero high half, so the flag must be 1. A design that sign-extended in unsigned mode, or zero-extended in signed mode, returns the wrong high half here. A design that tested the high half for zero in signed mode raises false overflows on small negative products such as -1 times 2, and misses the +32768 case. Truncating-form cases with `signed_mode` low show whether that form is forced to signed, because 0xFFFF times 2 then flags only under unsigned arithmetic. Hold cycles with changed operands and no request show whether the result registers capture without a request.

// File: rtl/mulu_pkg.sv
package mulu_pkg;
  parameter int unsigned MUL_W  = 16;
  localparam int unsigned PROD_W = 2 * MUL_W;

  // Multiplier build variant
  typedef enum logic [0:0] {
    MUL_OPERATOR = 1'b0,
    MUL_SHIFTADD = 1'b1
  } mul_style_e;
endpackage

// File: rtl/mulu_extend.sv
module mulu_extend #(
  parameter int unsigned W = mulu_pkg::MUL_W
) (
  input  logic [W-1:0]   d,
  input  logic           sx,
  output logic [2*W-1:0] q
);
  always_comb begin
    q = sx ? {{W{d[W-1]}}, d} : {{W{1'b0}}, d};
  end
endmodule

// File: rtl/mulu_core.sv
module mulu_core #(
  parameter int unsigned          W     = mulu_pkg::MUL_W,
  parameter mulu_pkg::mul_style_e STYLE = mulu_pkg::MUL_OPERATOR
) (
  input  logic [2*W-1:0] a_x,
  input  logic [2*W-1:0] b_x,
  output logic [2*W-1:0] p
);
  localparam int unsigned PW = 2 * W;

  generate
    if (STYLE == mulu_pkg::MUL_OPERATOR) begin : g_op
      always_comb begin
        p = a_x * b_x;
      end
    end else begin : g_shift
      logic [PW-1:0] acc;
      always_comb begin
        acc = '0;
        for (int i = 0; i < PW; i++) begin
          if (b_x[i]) acc = acc + (a_x << i);
        end
        p = acc;
      end
    end
  endgenerate
endmodule

// File: rtl/mulu_flags.sv
module mulu_flags #(
  parameter int unsigned W = mulu_pkg::MUL_W
) (
  input  logic [W-1:0] hi,
  input  logic         lo_msb,
  input  logic         sx,
  output logic         wide
);
  logic [W-1:0] redundant_hi;

  always_comb begin
    // High half carries nothing when it is a plain extension of the low half
    redundant_hi = sx ? {W{lo_msb}} : '0;
    wide         = (hi != redundant_hi);
  end
endmodule

// File: rtl/mul16_flag_unit.sv
module mul16_flag_unit #(
  parameter int unsigned          W     = mulu_pkg::MUL_W,
  parameter mulu_pkg::mul_style_e STYLE = mulu_pkg::MUL_OPERATOR
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         signed_mode,
  input  logic         narrow_form,
  output logic         out_valid,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] prod_hi,
  output logic         carry_out,
  output logic         ovf_out
);
  localparam int unsigned PW = 2 * W;

  logic          eff_signed;
  logic [PW-1:0] a_x, b_x, full_p;
  logic          wide_flag;

  // Truncating form is always two's complement
  assign eff_signed = signed_mode | narrow_form;

  mulu_extend #(.W(W)) u_ext_a (.d(op_a), .sx(eff_signed), .q(a_x));
  mulu_extend #(.W(W)) u_ext_b (.d(op_b), .sx(eff_signed), .q(b_x));

  mulu_core #(.W(W), .STYLE(STYLE)) u_core (.a_x(a_x), .b_x(b_x), .p(full_p));

  mulu_flags #(.W(W)) u_flags (
    .hi    (full_p[PW-1:W]),
    .lo_msb(full_p[W-1]),
    .sx    (eff_signed),
    .wide  (wide_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      prod_lo   <= '0;
      prod_hi   <= '0;
      carry_out <= 1'b0;
      ovf_out   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        prod_lo   <= full_p[W-1:0];
        prod_hi   <= narrow_form ? '0 : full_p[PW-1:W];
        carry_out <= wide_flag;
        ovf_out   <= wide_flag;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_flags_equal_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (carry_out == ovf_out));
  assert_narrow_hi_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && narrow_form) |=> (prod_hi == '0));
  assert_unsigned_zero_no_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !signed_mode && !narrow_form && op_a == '0) |=> !carry_out);
  assert_times_one_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_b == W'(1)) |=> !carry_out);
  assert_hold_lo_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(prod_lo) && $stable(prod_hi) && $stable(carry_out));
endmodule

// File: tb/test_mul16_flag_unit.sv
module test_mul16_flag_unit;
  localparam int  W   = 16;
  localparam time CLK = 8ns;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [W-1:0] op_a, op_b;
  logic         signed_mode, narrow_form;
  logic         out_valid;
  logic [W-1:0] prod_lo, prod_hi;
  logic         carry_out, ovf_out;

  int checks = 0;
  int fails  = 0;

  always #(CLK/2) clk = ~clk;

  mul16_flag_unit i_mul16_flag_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .signed_mode(signed_mode), .narrow_form(narrow_form),
    .out_valid(out_valid), .prod_lo(prod_lo), .prod_hi(prod_hi),
    .carry_out(carry_out), .ovf_out(ovf_out)
  );

  // Vector: {signed_mode, narrow_form, op_a, op_b}
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h1234, 16'h5678},
    {1'b1, 1'b0, 16'h1234, 16'h5678},
    {1'b1, 1'b0, 16'hFFFF, 16'h0002},
    {1'b0, 1'b0, 16'hFFFF, 16'h0002},
    {1'b1, 1'b0, 16'h7FFF, 16'h7FFF},
    {1'b1, 1'b0, 16'h8001, 16'h0003},
    {1'b0, 1'b0, 16'h00FF, 16'h0101},
    {1'b0, 1'b0, 16'h0100, 16'h0100},
    {1'b1, 1'b1, 16'h0123, 16'hFFF0},
    {1'b0, 1'b1, 16'h4000, 16'h0004},
    {1'b1, 1'b0, 16'hC000, 16'h0002},
    {1'b1, 1'b0, 16'hBFFF, 16'h0002},
    {1'b0, 1'b0, 16'hABCD, 16'h0000},
    {1'b1, 1'b1, 16'h00B5, 16'h00B5}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent model from the requirements
  function automatic logic [32:0] model(input logic sg, input logic nr,
                                        input logic [15:0] a, input logic [15:0] b);
    logic        es;
    logic [31:0] ax, bx, p;
    logic [15:0] hi_o;
    logic        fl;
    es = sg | nr;
    ax = es ? {{16{a[15]}}, a} : {16'h0, a};
    bx = es ? {{16{b[15]}}, b} : {16'h0, b};
    p  = ax * bx;
    fl = es ? (p[31:16] != {16{p[15]}}) : (p[31:16] != 16'h0);
    hi_o = nr ? 16'h0 : p[31:16];
    return {fl, hi_o, p[15:0]};
  endfunction

  task automatic issue(input logic sg, input logic nr,
                       input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    signed_mode = sg; narrow_form = nr; op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_result(input string req, input logic [15:0] lo,
                              input logic [15:0] hi, input logic fl);
    check(req, "out_valid", {31'h0, out_valid}, 32'h1);
    check(req, "product", {prod_hi, prod_lo}, {hi, lo});
    check(req, "carry", {31'h0, carry_out}, {31'h0, fl});
    check("R8", "ovf", {31'h0, ovf_out}, {31'h0, fl});
  endtask

  initial begin
    #(CLK * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [32:0] e;
    rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0;
    signed_mode = 1'b0; narrow_form = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset outputs", {13'h0, out_valid, prod_lo, prod_hi, carry_out, ovf_out}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R2", "idle valid", {31'h0, out_valid}, 32'h0);

    // Table walk: R3/R4/R5/R6/R7 against model
    for (int k = 0; k < NV; k++) begin
      issue(VEC[k][33], VEC[k][32], VEC[k][31:16], VEC[k][15:0]);
      e = model(VEC[k][33], VEC[k][32], VEC[k][31:16], VEC[k][15:0]);
      check_result(VEC[k][32] ? "R7" : (VEC[k][33] ? "R4/R6" : "R3/R5"),
                   e[15:0], e[31:16], e[32]);
    end

    // Directed corners with hand-computed values
    issue(1'b0, 1'b0, 16'hFFFF, 16'hFFFF);
    check_result("R3", 16'h0001, 16'hFFFE, 1'b1);
    issue(1'b1, 1'b0, 16'h8000, 16'h8000);
    check_result("R4", 16'h0000, 16'h4000, 1'b1);
    issue(1'b1, 1'b0, 16'h8000, 16'hFFFF);
    check_result("R6", 16'h8000, 16'h0000, 1'b1);
    issue(1'b1, 1'b0, 16'hFFFF, 16'hFFFF);
    check_result("R6", 16'h0001, 16'h0000, 1'b0);
    issue(1'b1, 1'b0, 16'hFFFF, 16'h0002);
    check_result("R6", 16'hFFFE, 16'hFFFF, 1'b0);
    issue(1'b0, 1'b0, 16'h0000, 16'hFFFF);
    check_result("R5", 16'h0000, 16'h0000, 1'b0);
    issue(1'b0, 1'b0, 16'hFFFF, 16'h0001);
    check_result("R5", 16'hFFFF, 16'h0000, 1'b0);
    issue(1'b0, 1'b0, 16'h0100, 16'h0100);
    check_result("R5", 16'h0000, 16'h0001, 1'b1);
    // R7: truncating form forced signed even with signed_mode=0
    issue(1'b0, 1'b1, 16'hFFFF, 16'h0002);
    check_result("R7", 16'hFFFE, 16'h0000, 1'b0);
    issue(1'b0, 1'b1, 16'h4000, 16'h0004);
    check_result("R7", 16'h0000, 16'h0000, 1'b1);
    issue(1'b1, 1'b1, 16'h8000, 16'h0001);
    check_result("R7", 16'h8000, 16'h0000, 1'b0);

    // R9: no request, changed operands, outputs hold
    issue(1'b0, 1'b0, 16'hFFFF, 16'hFFFF);
    @(negedge clk);
    signed_mode = 1'b1; narrow_form = 1'b0; op_a = 16'h7FFF; op_b = 16'h7FFF;
    repeat (3) @(negedge clk);
    check("R9", "held product", {prod_hi, prod_lo}, 32'hFFFE0001);
    check("R9", "held carry", {31'h0, carry_out}, 32'h1);
    check("R2", "valid low when idle", {31'h0, out_valid}, 32'h0);

    // R2 back-to-back requests
    @(negedge clk);
    signed_mode = 1'b0; narrow_form = 1'b0; op_a = 16'h0003; op_b = 16'h0005; in_valid = 1'b1;
    @(negedge clk);
    check("R2", "b2b first", {out_valid, prod_lo}, {1'b1, 16'h000F});
    op_a = 16'h0007; op_b = 16'h0009;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", "b2b second", {out_valid, prod_lo}, {1'b1, 16'h003F});
    @(negedge clk);
    check("R2", "b2b end", {31'h0, out_valid}, 32'h0);

    // R1: reset after activity
    rst = 1'b1;
    @(negedge clk);
    check("R1", "reset after use", {13'h0, out_valid, prod_lo, prod_hi, carry_out, ovf_out}, 32'h0);
    rst = 1'b0;

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule